// File: doc/BRIEF.md
# QoS-Aware Shared Request Queue Admission

This block sits in front of a memory controller and collects requests from three traffic classes into one shared request queue of sixteen slots. Each class has its own request port carrying a QoS level and a tag. Bulk traffic, which cares about throughput, may occupy the queue only up to a high-water mark set on an input. The slots above that mark stay free for the two latency-critical classes. Bulk requests held back at admission therefore never stop an urgent request from entering.

Only one request is admitted per cycle. Fixed priority settles contention between the classes. The queue hands out its contents on a single dequeue port. The entry with the highest QoS goes first. Among entries of equal QoS, the oldest goes first. So an urgent request that arrives late can still overtake bulk work that is already waiting. An admission and a dequeue may happen in the same cycle.

Top module: `qadm_top`

## Requirements
- R1: Class codes on `deq_cls` are 0 = minimum-latency, 1 = deadline, 2 = bulk. After reset the queue is empty and `deq_valid` is 0. `deq_valid` is 1 exactly while at least one entry is stored.
- R2: A bulk request (class 2) is accepted only while the number of stored entries is below `hwm_i`, which is used in the range 1 to 15.
- R3: A minimum-latency request (class 0) sees ready whenever fewer than 16 entries are stored. This holds whatever the bulk port is doing.
- R4: With 16 entries stored, all three ready outputs are 0.
- R5: At most one request is accepted per cycle. Class 0 has priority over class 1, and class 1 over class 2. A class sees ready low in any cycle where a higher-priority class is asserting valid.
- R6: A dequeue always delivers a stored entry whose QoS is the highest of all stored entries.
- R7: Among stored entries of equal QoS, the one accepted earliest is dequeued first.
- R8: When a request is accepted and an entry is dequeued in the same cycle, both take effect. The occupancy is unchanged, and no entry is lost or duplicated.
- R9: A dequeued entry carries the class, QoS and tag it had when it was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hwm_i | input | 4 | Occupancy limit for bulk admission |
| req_valid | input | 3 | Per-class request valid, bit index = class code |
| req_ready | output | 3 | Per-class accept |
| req_qos | input | 12 | Per-class QoS, 4 bits per class, class c at bits [4c+3:4c] |
| req_tag | input | 24 | Per-class tag, 8 bits per class, class c at bits [8c+7:8c] |
| deq_valid | output | 1 | Queue holds at least one entry |
| deq_ready | input | 1 | Consumer takes the presented entry |
| deq_cls | output | 2 | Class of the presented entry |
| deq_qos | output | 4 | QoS of the presented entry |
| deq_tag | output | 8 | Tag of the presented entry |

## Verification
Two kinds of collision are provoked on purpose.

The first is admission and dequeue in the same cycle. It is driven by holding `deq_ready` high while classes keep asserting valid on a partly filled queue. It is judged by the scoreboard occupancy, which must keep predicting every ready output, and by the order of the drained entries.

The second is several classes contending for one admission slot. All three valids are raised together while the queue is filling and again when it is full. Each cycle the ready pattern is compared with the priority order, the full condition and the high-water mark.

// File: rtl/qadm_pkg.sv
package qadm_pkg;

    localparam int NCLS   = 3;
    localparam int QOS_W  = 4;
    localparam int TAG_W  = 8;
    localparam int DEPTH  = 16;
    localparam int CLS_W  = 2;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef enum logic [CLS_W-1:0] {
        CLS_MINLAT   = 2'd0,
        CLS_DEADLINE = 2'd1,
        CLS_BULK     = 2'd2
    } cls_e;

    typedef struct packed {
        cls_e             cls;
        logic [QOS_W-1:0] qos;
        logic [TAG_W-1:0] tag;
    } ent_t;

    // Bulk class is the only one bounded by the high-water mark.
    function automatic logic hwm_bound(input int c);
        return c == int'(CLS_BULK);
    endfunction

endpackage

// File: rtl/qadm_admit.sv
module qadm_admit
    import qadm_pkg::*;
#(
    parameter int N_CLS = NCLS,
    parameter int DEP   = DEPTH,
    parameter int CW    = CNT_W,
    parameter int HW    = IDX_W
) (
    input  logic [N_CLS-1:0] req_valid,
    input  logic [CW-1:0]    occ,
    input  logic [HW-1:0]    hwm,
    output logic [N_CLS-1:0] req_ready,
    output logic             grant_vld,
    output cls_e             grant_cls
);

    logic             full;
    logic [N_CLS-1:0] elig;
    logic [N_CLS-1:0] shadowed;
    logic [N_CLS-1:0] taken;

    assign full = (occ == CW'(DEP));

    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        if (hwm_bound(c)) begin : g_bounded
            assign elig[c] = !full && (occ < CW'(hwm));
        end else begin : g_open
            assign elig[c] = !full;
        end
        if (c == 0) begin : g_top
            assign shadowed[c] = 1'b0;
        end else begin : g_lower
            assign shadowed[c] = |req_valid[c-1:0];
        end
        assign req_ready[c] = elig[c] && !shadowed[c];
    end

    assign taken     = req_valid & req_ready;
    assign grant_vld = |taken;

    always_comb begin
        grant_cls = CLS_MINLAT;
        for (int c = N_CLS - 1; c >= 0; c--) begin
            if (taken[c]) grant_cls = cls_e'(c[CLS_W-1:0]);
        end
    end

endmodule

// File: rtl/qadm_pick.sv
module qadm_pick
    import qadm_pkg::*;
#(
    parameter int DEP = DEPTH,
    parameter int CW  = CNT_W,
    parameter int IW  = IDX_W
) (
    input  ent_t          ents [DEP],
    input  logic [CW-1:0] occ,
    output logic [IW-1:0] sel_idx
);

    logic [QOS_W-1:0] best_qos;

    // Strict comparison keeps the lowest (oldest) index on QoS ties.
    always_comb begin
        sel_idx  = '0;
        best_qos = ents[0].qos;
        for (int i = 1; i < DEP; i++) begin
            if (CW'(i) < occ && ents[i].qos > best_qos) begin
                best_qos = ents[i].qos;
                sel_idx  = IW'(i);
            end
        end
    end

endmodule

// File: rtl/qadm_store.sv
module qadm_store
    import qadm_pkg::*;
#(
    parameter int DEP = DEPTH,
    parameter int CW  = CNT_W,
    parameter int IW  = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enq,
    input  ent_t          enq_ent,
    input  logic          deq,
    input  logic [IW-1:0] deq_idx,
    output ent_t          ents [DEP],
    output logic [CW-1:0] occ
);

    ent_t          ents_nx [DEP];
    logic [CW-1:0] occ_nx;
    logic [CW-1:0] wpos;

    // Entries are kept in arrival order at indices 0..occ-1.
    always_comb begin
        for (int i = 0; i < DEP; i++) ents_nx[i] = ents[i];
        if (deq) begin
            for (int i = 0; i < DEP - 1; i++) begin
                if (IW'(i) >= deq_idx) ents_nx[i] = ents[i+1];
            end
        end
        wpos = occ - CW'(deq);
        if (enq) ents_nx[wpos[IW-1:0]] = enq_ent;
        occ_nx = occ + CW'(enq) - CW'(deq);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
            for (int i = 0; i < DEP; i++) ents[i] <= '0;
        end else begin
            occ <= occ_nx;
            for (int i = 0; i < DEP; i++) ents[i] <= ents_nx[i];
        end
    end

endmodule

// File: rtl/qadm_top.sv
module qadm_top
    import qadm_pkg::*;
#(
    parameter int N_CLS = NCLS,
    parameter int DEP   = DEPTH,
    parameter int QW    = QOS_W,
    parameter int TW    = TAG_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    hwm_i,
    input  logic [N_CLS-1:0]    req_valid,
    output logic [N_CLS-1:0]    req_ready,
    input  logic [N_CLS*QW-1:0] req_qos,
    input  logic [N_CLS*TW-1:0] req_tag,
    output logic                deq_valid,
    input  logic                deq_ready,
    output logic [CLS_W-1:0]    deq_cls,
    output logic [QW-1:0]       deq_qos,
    output logic [TW-1:0]       deq_tag
);

    localparam int CW = $clog2(DEP + 1);
    localparam int IW = $clog2(DEP);

    logic          grant_vld;
    cls_e          grant_cls;
    ent_t          new_ent;
    ent_t          ents [DEP];
    logic [CW-1:0] occ;
    logic [IW-1:0] sel_idx;
    logic          do_deq;
    ent_t          head;

    qadm_admit #(.N_CLS(N_CLS), .DEP(DEP), .CW(CW), .HW(IDX_W)) u_admit (
        .req_valid (req_valid),
        .occ       (occ),
        .hwm       (hwm_i),
        .req_ready (req_ready),
        .grant_vld (grant_vld),
        .grant_cls (grant_cls)
    );

    always_comb begin
        new_ent.cls = grant_cls;
        new_ent.qos = req_qos[int'(grant_cls)*QW +: QW];
        new_ent.tag = req_tag[int'(grant_cls)*TW +: TW];
    end

    qadm_pick #(.DEP(DEP), .CW(CW), .IW(IW)) u_pick (
        .ents    (ents),
        .occ     (occ),
        .sel_idx (sel_idx)
    );

    assign deq_valid = (occ != '0);
    assign do_deq    = deq_valid && deq_ready;

    qadm_store #(.DEP(DEP), .CW(CW), .IW(IW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .enq     (grant_vld),
        .enq_ent (new_ent),
        .deq     (do_deq),
        .deq_idx (sel_idx),
        .ents    (ents),
        .occ     (occ)
    );

    assign head    = ents[sel_idx];
    assign deq_cls = head.cls;
    assign deq_qos = head.qos;
    assign deq_tag = head.tag;

endmodule

// File: rtl/qadm_chk.sv
module qadm_chk
    import qadm_pkg::*;
#(
    parameter int N_CLS = NCLS,
    parameter int DEP   = DEPTH,
    parameter int CW    = CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] hwm,
    input logic [N_CLS-1:0] req_valid,
    input logic [N_CLS-1:0] req_ready,
    input logic             deq_valid,
    input logic             deq_ready,
    input logic [CW-1:0]    occ
);

    logic past_ok;
    logic enq_w;
    logic deq_w;

    assign enq_w = |(req_valid & req_ready);
    assign deq_w = deq_valid && deq_ready;

    always_ff @(posedge clk) past_ok <= !rst;

    assert_empty_flag_R1: assert property (@(posedge clk) disable iff (rst)
        deq_valid == (occ != '0));

    assert_bulk_below_mark_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid[2] && req_ready[2]) |-> (occ < CW'(hwm)));

    assert_urgent_open_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid[0] && occ < CW'(DEP)) |-> req_ready[0]);

    assert_full_closed_R4: assert property (@(posedge clk) disable iff (rst)
        (occ == CW'(DEP)) |-> (req_ready == '0));

    assert_single_accept_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(req_valid & req_ready) <= 1);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEP));

    assert_occ_tracks_R8: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (occ == $past(occ) + CW'($past(enq_w)) - CW'($past(deq_w))));

endmodule

bind qadm_top qadm_chk #(.N_CLS(N_CLS), .DEP(DEP), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hwm       (hwm_i),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .deq_valid (deq_valid),
    .deq_ready (deq_ready),
    .occ       (occ)
);

// File: tb/test_qadm_top.sv
`timescale 1ns/1ps
module test_qadm_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  hwm_i = 4'd4;
    logic [2:0]  req_valid = '0;
    logic [2:0]  req_ready;
    logic [11:0] req_qos = '0;
    logic [23:0] req_tag = '0;
    logic        deq_valid;
    logic        deq_ready = 1'b0;
    logic [1:0]  deq_cls;
    logic [3:0]  deq_qos;
    logic [7:0]  deq_tag;

    typedef struct {int cls; int qos; int tag;} item_t;
    item_t sbq[$];

    int nchk = 0;
    int nfail = 0;
    int seq = 0;
    int both_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    qadm_top i_qadm_top (
        .clk(clk), .rst(rst), .hwm_i(hwm_i),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_qos(req_qos), .req_tag(req_tag),
        .deq_valid(deq_valid), .deq_ready(deq_ready),
        .deq_cls(deq_cls), .deq_qos(deq_qos), .deq_tag(deq_tag)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: predicts readies from the scoreboard, pops and compares dequeues.
    always @(negedge clk) begin
        if (!rst && !done) begin
            int sz;
            bit [2:0] er;
            bit enq_seen;
            sz = sbq.size();
            er[0] = sz < 16;
            er[1] = sz < 16 && !req_valid[0];
            er[2] = sz < 16 && sz < int'(hwm_i) && !req_valid[0] && !req_valid[1];
            for (int c = 0; c < 3; c++) begin
                string r;
                r = (sz == 16) ? "R4" : (c == 0) ? "R3" : (c == 1) ? "R5" : "R2";
                chk(req_ready[c] === er[c], r, $sformatf("ready[%0d] occ=%0d", c, sz),
                    int'(req_ready[c]), int'(er[c]));
            end
            chk(deq_valid === (sz != 0), "R1", "deq_valid", int'(deq_valid), int'(sz != 0));
            enq_seen = |(req_valid & req_ready);
            if (deq_valid && deq_ready && sz != 0) begin
                int bi;
                bi = 0;
                for (int i = 1; i < sz; i++) if (sbq[i].qos > sbq[bi].qos) bi = i;
                chk(int'(deq_qos) == sbq[bi].qos, "R6", "deq_qos", int'(deq_qos), sbq[bi].qos);
                chk(int'(deq_tag) == sbq[bi].tag, "R7", "deq_tag order", int'(deq_tag), sbq[bi].tag);
                chk(int'(deq_cls) == sbq[bi].cls, "R9", "deq_cls", int'(deq_cls), sbq[bi].cls);
                sbq.delete(bi);
                if (enq_seen) both_cnt++;
            end
            for (int c = 0; c < 3; c++) begin
                if (req_valid[c] && req_ready[c]) begin
                    item_t it;
                    it.cls = c;
                    it.qos = int'(req_qos[c*4 +: 4]);
                    it.tag = int'(req_tag[c*8 +: 8]);
                    sbq.push_back(it);
                end
            end
        end
    end

    // Driver: mode 0 spreads QoS, mode 1 uses one QoS for all, mode 2 QoS = class.
    task automatic run(input logic [2:0] v, input int mode, input bit dr, input int n);
        repeat (n) begin
            @(posedge clk); #1;
            req_valid = v;
            deq_ready = dr;
            for (int c = 0; c < 3; c++) begin
                int q;
                q = (mode == 0) ? ((seq * 5 + c * 3) % 16) : (mode == 1) ? 7 : c;
                req_qos[c*4 +: 4] = 4'(q);
                req_tag[c*8 +: 8] = 8'(seq * 3 + c);
            end
            seq++;
        end
    endtask

    task automatic set_hwm(input int h);
        @(posedge clk); #1;
        req_valid = '0;
        deq_ready = 1'b0;
        hwm_i = 4'(h);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(deq_valid === 1'b0, "R1", "deq_valid after reset", int'(deq_valid), 0);
        chk(req_ready === 3'b111, "R1", "ready after reset", int'(req_ready), 7);
        // R2: bulk alone stops at the mark of 4
        run(3'b100, 0, 0, 8);
        // R5: all classes contend, class 0 wins
        run(3'b111, 0, 0, 6);
        run(3'b110, 0, 0, 4);
        // R3: deadline class fills reserved slots up to full
        run(3'b010, 0, 0, 4);
        // R4: full queue refuses everyone
        run(3'b111, 0, 0, 3);
        // R6 R9: drain with mixed QoS
        run(3'b000, 0, 1, 18);
        // R7: equal QoS drains in arrival order
        set_hwm(15);
        run(3'b100, 1, 0, 5);
        run(3'b010, 1, 0, 3);
        run(3'b001, 1, 0, 2);
        run(3'b000, 0, 1, 12);
        // R8: admission and dequeue in the same cycles
        run(3'b100, 0, 0, 3);
        run(3'b001, 0, 1, 10);
        run(3'b011, 2, 1, 6);
        run(3'b110, 0, 1, 8);
        run(3'b000, 0, 1, 20);
        // R2: lowest mark admits a single bulk entry
        set_hwm(1);
        run(3'b100, 0, 0, 4);
        run(3'b001, 0, 0, 3);
        run(3'b000, 0, 1, 6);
        @(negedge clk);
        chk(both_cnt > 0, "R8", "cycles with enqueue and dequeue", both_cnt, 1);
        chk(sbq.size() == 0, "R8", "entries left", sbq.size(), 0);
        chk(deq_valid === 1'b0, "R8", "deq_valid when drained", int'(deq_valid), 0);
        finish_run();
    end

endmodule